// File: doc/BRIEF.md
# Two-Stage Pipelined Wide Magnitude Comparator

This block takes two wide unsigned operands and reports, two clock cycles later, whether the first is greater than, equal to, or less than the second. It does not build one full-width carry chain. The first cycle slices both operands into equal-width segments and compares each slice pair on its own. Every slice yields a "greater" flag and an "equal" flag, and all of these are registered.

The second cycle merges the registered slice flags in priority order. The highest slice whose pair differs decides the answer. A lower slice counts only while every slice above it compares equal. Full-width equality is the AND of all slice equality flags. The slice width is a parameter that must divide the operand width evenly. Narrow slices make the first cycle shallower and the merge chain longer, and wide slices do the reverse. The default is 128-bit operands in four 32-bit slices, sized for about 125 MHz.

A new operand pair may be presented on every clock. Results come out in the order the pairs went in, one per clock.

Top module: `wide_mag_compare`

## Requirements
- R1: `out_valid` is high exactly two rising clock edges after the edge that sampled `in_valid` high, and low two edges after `in_valid` was sampled low. Back-to-back pairs give back-to-back results.
- R2: While `out_valid` is high, `out_gt` is 1 exactly when the unsigned value of `a` exceeds that of `b` for the pair that produced the result.
- R3: While `out_valid` is high, `out_eq` is 1 exactly when `a` equals `b` bit for bit.
- R4: While `out_valid` is high, `out_lt` is 1 exactly when `a` is below `b`, and exactly one of `out_gt`, `out_eq`, `out_lt` is 1.
- R5: While `out_valid` is low, `out_gt`, `out_eq` and `out_lt` are all 0.
- R6: The most significant differing segment alone decides the result. A difference in any lower segment in the opposite direction does not change it.
- R7: `rst_n` is synchronous and active low. The rising edge that samples it low clears `out_valid` and all three flags, and it drops any pair already in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Qualifies `a` and `b` this cycle |
| a | input | WIDTH | First unsigned operand |
| b | input | WIDTH | Second unsigned operand |
| out_valid | output | 1 | Result flags are meaningful |
| out_gt | output | 1 | `a` greater than `b` |
| out_eq | output | 1 | `a` equal to `b` |
| out_lt | output | 1 | `a` less than `b` |

## Verification
Each result is due on the second rising edge after its operands are sampled, with one edge for the slice-flag register and one for the merged result register. A reset sampled low shows at the port after a single edge. The bench drives inputs on falling edges and keeps a two-entry queue of expected results, which it computes from plain integer comparison. At every falling edge it compares the ports against the entry that entered the queue two cycles earlier. When reset is driven, it zeroes both queue entries, because the next two outputs must then be empty. A small 8-bit configuration with four 2-bit slices is swept over every operand pair. Directed cases then cover valid gaps, a reset in mid-stream, and opposing lower-slice differences.

// File: rtl/wcmp_pkg.sv
// Package: shared types for the wide magnitude comparator.
// Assumes nothing beyond a plain two-flag result per operand slice.
package wcmp_pkg;

    // Per-slice compare outcome carried from stage one to stage two.
    typedef struct packed {
        logic gt;   // slice of a above slice of b
        logic eq;   // slices identical
    } slice_flags_t;

    // Three-way outcome as it leaves the merge stage.
    typedef struct packed {
        logic gt;
        logic eq;
        logic lt;
    } cmp_result_t;

endpackage

// File: rtl/wcmp_slice_cmp.sv
// Module: wcmp_slice_cmp
// Purely combinational compare of one operand slice pair.
// Assumes both slices are unsigned and SEG_W bits wide. It has no state.
module wcmp_slice_cmp
    import wcmp_pkg::*;
#(
    parameter int SEG_W = 32
) (
    input  logic [SEG_W-1:0] seg_a,
    input  logic [SEG_W-1:0] seg_b,
    output slice_flags_t     flags
);

    // Derive both flags for this slice with a short local compare.
    always_comb begin
        flags.gt = (seg_a > seg_b);
        flags.eq = (seg_a == seg_b);
    end

endmodule

// File: rtl/wcmp_flag_stage.sv
// Module: wcmp_flag_stage
// Pipeline stage one. It cuts both operands into NSEG slices, compares every
// slice pair in parallel and registers the gt/eq flags with a valid bit.
// Assumes SEG_W divides WIDTH. Slice 0 holds the least significant bits.
module wcmp_flag_stage
    import wcmp_pkg::*;
#(
    parameter int WIDTH = 128,
    parameter int SEG_W = 32,
    localparam int NSEG = WIDTH / SEG_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [WIDTH-1:0]     a,
    input  logic [WIDTH-1:0]     b,
    output logic                 s1_valid,
    output slice_flags_t [NSEG-1:0] s1_flags
);

    slice_flags_t [NSEG-1:0] flags_now;

    // One comparator per slice. The loop bound comes from the parameters.
    for (genvar s = 0; s < NSEG; s++) begin : g_slice
        wcmp_slice_cmp #(
            .SEG_W(SEG_W)
        ) u_slice (
            .seg_a(a[s*SEG_W +: SEG_W]),
            .seg_b(b[s*SEG_W +: SEG_W]),
            .flags(flags_now[s])
        );
    end

    // Register the slice flags and the valid bit. Reset empties the stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_flags <= '0;
        end else begin
            s1_valid <= in_valid;
            s1_flags <= flags_now;
        end
    end

endmodule

// File: rtl/wcmp_merge_stage.sv
// Module: wcmp_merge_stage
// Pipeline stage two. It folds the registered slice flags into one three-way
// result. The fold is a select chain: a slice's own gt wins unless the slice
// is equal, in which case the next lower slice's verdict passes through.
// Assumes slice NSEG-1 is the most significant. Flags are zero when idle.
module wcmp_merge_stage
    import wcmp_pkg::*;
#(
    parameter int NSEG = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    s1_valid,
    input  slice_flags_t [NSEG-1:0] s1_flags,
    output logic                    out_valid,
    output cmp_result_t             result
);

    logic [NSEG-1:0] gt_upto;   // verdict over slices [i:0]
    logic [NSEG-1:0] eq_upto;   // all slices [i:0] equal
    cmp_result_t     merged;

    // Bottom link of the chain: slice 0 decides on its own.
    assign gt_upto[0] = s1_flags[0].gt;
    assign eq_upto[0] = s1_flags[0].eq;

    // Upper links: an equal slice defers to the chain below it.
    for (genvar i = 1; i < NSEG; i++) begin : g_link
        assign gt_upto[i] = s1_flags[i].eq ? gt_upto[i-1] : s1_flags[i].gt;
        assign eq_upto[i] = s1_flags[i].eq & eq_upto[i-1];
    end

    // Form the three-way verdict. Less is whatever is neither of the others.
    always_comb begin
        merged.gt = gt_upto[NSEG-1];
        merged.eq = eq_upto[NSEG-1];
        merged.lt = ~gt_upto[NSEG-1] & ~eq_upto[NSEG-1];
    end

    // Register the verdict and gate it with valid so idle cycles read zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= s1_valid;
            result    <= s1_valid ? merged : '0;
        end
    end

endmodule

// File: rtl/wide_mag_compare.sv
// Module: wide_mag_compare
// Top of the two-stage unsigned magnitude comparator. It accepts one operand
// pair per clock and returns gt/eq/lt two clocks later.
// Assumes SEG_W divides WIDTH. Operands held for one cycle are enough.
module wide_mag_compare
    import wcmp_pkg::*;
#(
    parameter int WIDTH = 128,
    parameter int SEG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic             out_valid,
    output logic             out_gt,
    output logic             out_eq,
    output logic             out_lt
);

    localparam int NSEG = WIDTH / SEG_W;

    logic                    s1_valid;
    slice_flags_t [NSEG-1:0] s1_flags;
    cmp_result_t             result;

    // Stage one: per-slice flags.
    wcmp_flag_stage #(
        .WIDTH(WIDTH),
        .SEG_W(SEG_W)
    ) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_valid(in_valid),
        .a       (a),
        .b       (b),
        .s1_valid(s1_valid),
        .s1_flags(s1_flags)
    );

    // Stage two: priority merge of the slice flags.
    wcmp_merge_stage #(
        .NSEG(NSEG)
    ) u_merge (
        .clk      (clk),
        .rst_n    (rst_n),
        .s1_valid (s1_valid),
        .s1_flags (s1_flags),
        .out_valid(out_valid),
        .result   (result)
    );

    assign out_gt = result.gt;
    assign out_eq = result.eq;
    assign out_lt = result.lt;

endmodule

// File: rtl/wcmp_checker.sv
// Module: wcmp_checker
// Bound checker for wide_mag_compare. It keeps its own two-deep history of
// valid and operands and checks the port results against that history.
module wcmp_checker #(
    parameter int WIDTH = 128,
    parameter int SEG_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic             out_valid,
    input logic             out_gt,
    input logic             out_eq,
    input logic             out_lt
);

    logic             v_d1, v_d2;
    logic [WIDTH-1:0] a_d1, a_d2, b_d1, b_d2;

    // Track the inputs two cycles back for the reference compare.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_d1 <= 1'b0;
            v_d2 <= 1'b0;
        end else begin
            v_d1 <= in_valid;
            v_d2 <= v_d1;
        end
        a_d1 <= a;
        a_d2 <= a_d1;
        b_d1 <= b;
        b_d2 <= b_d1;
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == v_d2); // R1

    AST_GT_REF: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_gt == (a_d2 > b_d2))); // R2

    AST_EQ_REF: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_eq == (a_d2 == b_d2))); // R3

    AST_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones({out_gt, out_eq, out_lt}) == 1)); // R4

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ({out_gt, out_eq, out_lt} == 3'b000)); // R5

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && {out_gt, out_eq, out_lt} == 3'b000)); // R7

endmodule

bind wide_mag_compare wcmp_checker #(
    .WIDTH(WIDTH),
    .SEG_W(SEG_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .a        (a),
    .b        (b),
    .out_valid(out_valid),
    .out_gt   (out_gt),
    .out_eq   (out_eq),
    .out_lt   (out_lt)
);

// File: tb/tb_wide_mag_compare.sv
module tb_wide_mag_compare;

    localparam int W  = 8;
    localparam int SW = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic         out_valid, out_gt, out_eq, out_lt;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Expected-result queue: entry 1 was driven last cycle, entry 2 before that.
    logic         e1_v = 1'b0, e2_v = 1'b0;
    logic [W-1:0] e1_a = '0, e2_a = '0, e1_b = '0, e2_b = '0;
    string        e1_tag = "R7", e2_tag = "R7";

    always #2 clk = ~clk;

    wide_mag_compare #(.WIDTH(W), .SEG_W(SW)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a), .b(b),
        .out_valid(out_valid), .out_gt(out_gt), .out_eq(out_eq), .out_lt(out_lt)
    );

    task automatic check_now();
        logic [3:0] got, exp;
        got = {out_valid, out_gt, out_eq, out_lt};
        if (e2_v) exp = {1'b1, e2_a > e2_b, e2_a == e2_b, e2_a < e2_b};
        else      exp = 4'b0000;
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s a=%0d b=%0d got v/gt/eq/lt=%b expected %b",
                     e2_tag, e2_a, e2_b, got, exp);
        end
    endtask

    // One cycle: check the due result, then drive the next stimulus.
    task automatic step(input bit rst, input bit v, input logic [W-1:0] va,
                        input logic [W-1:0] vb, input string tag);
        @(negedge clk);
        check_now();
        rst_n = ~rst; in_valid = v; a = va; b = vb;
        if (rst) begin
            e2_v = 1'b0; e1_v = 1'b0; e2_tag = "R7"; e1_tag = "R7";
        end else begin
            e2_v = e1_v; e2_a = e1_a; e2_b = e1_b; e2_tag = e1_tag;
            e1_v = v;    e1_a = va;   e1_b = vb;   e1_tag = tag;
        end
    endtask

    initial begin
        // Reset state, R7.
        for (int i = 0; i < 3; i++) step(1, 1, 8'hFF, 8'h00, "R7");
        // Exhaustive sweep, one pair per cycle: R1 R2 R3 R4 R6.
        for (int x = 0; x < 256; x++)
            for (int y = 0; y < 256; y++)
                step(0, 1, x[W-1:0], y[W-1:0], "R1_R2_R3_R4_R6");
        // Valid gaps must give zero flags, R5 and R1.
        for (int i = 0; i < 8; i++)
            step(0, i[0], 8'(i * 37), 8'(i * 11), "R5_R1");
        // Directed corners.
        step(0, 1, 8'hA5, 8'hA5, "R3");           // all equal
        step(0, 1, 8'h41, 8'h40, "R2");           // only LSB differs
        step(0, 1, 8'h00, 8'h80, "R4");           // only MSB differs
        step(0, 1, 8'b1010_0000, 8'b1001_1111, "R6"); // middle decides, lower opposite
        step(0, 1, 8'b0011_0011, 8'b0100_0000, "R6"); // top slice decides
        step(0, 0, 8'h00, 8'h00, "R5");
        // Reset with pairs in flight, R7.
        step(0, 1, 8'h10, 8'h01, "R2");
        step(0, 1, 8'h01, 8'h10, "R4");
        step(1, 1, 8'h22, 8'h22, "R7");
        step(0, 1, 8'h33, 8'h33, "R3");
        step(0, 0, 8'h00, 8'h00, "R5");
        step(0, 0, 8'h00, 8'h00, "R5");
        step(0, 0, 8'h00, 8'h00, "R5");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule